// File: doc/BRIEF.md
# SDRAM Refresh and Burst Sequencer

This block drives the four active-low command pins and the address bus of one SDRAM device. A host hands it one access at a time: a row, a list of columns (one per beat), a transfer size in bytes, and a read/write flag. The block turns that access into a timed command stream. An activate carries the row. A programmable number of idle cycles covers the row-to-column delay. One column command follows per beat. Writes get a recovery wait. A precharge-all closes the row, and a precharge recovery wait follows it. The number of beats is the transfer size divided by the port width in bytes (parameter `PORT_BYTES`, a power of two). Column k of the list sits at bits `[k*COL_W +: COL_W]` of the column input.

A down-counting timer loaded from a 16-bit reload input raises a sticky refresh request each time it reaches zero. The request is serviced only when the sequencer is idle, so a burst in progress always finishes first. The refresh cycle is a precharge-all, a tRP wait, an auto-refresh command and a recovery wait. `req_ready` is high only when the sequencer is idle and no refresh is pending. A host that holds `req_valid` is therefore stalled through the whole refresh cycle. All delays are 4-bit inputs, and a value of 0 inserts no wait cycles.

The sequencer states are IDLE, ACT, RCD, COL, RWL, PALL, RP, RF_PALL, RF_RP, RF_AREF and RF_REC. The transitions are as follows:
- IDLE goes to RF_PALL when a refresh is pending, or to ACT when a request is valid.
- ACT goes to RCD, or straight to COL when tRCD is 0. RCD goes to COL after tRCD cycles.
- COL stays in COL for each further beat. After the last beat it goes to RWL (a write with tRWL above 0) or to PALL.
- RWL goes to PALL after tRWL cycles.
- PALL goes to RP, or to IDLE when tRP is 0. RP goes to IDLE.
- RF_PALL goes to RF_RP, or to RF_AREF when tRP is 0. RF_RP goes to RF_AREF.
- RF_AREF goes to RF_REC, or to IDLE when the recovery count is 0. RF_REC goes to IDLE.

Top module: `sdram_seq_top`

## Requirements
- R1: After reset the command pins show NOP and `req_ready` is high.
- R2: A burst starts with ACTV (`cmd_n`=0011) carrying the row on `addr`. Exactly tRCD NOP cycles follow before the first column command, and none when tRCD is 0.
- R3: One column command per beat is issued on consecutive cycles: WRITE=0100 or READ=0101. Beat k carries column k of the list. There are `req_size/PORT_BYTES` beats.
- R4: After the last WRITE there are exactly tRWL NOPs, and after the last READ there are none. PALL (`cmd_n`=0010) follows, with address bit 10 high and all other address bits low.
- R5: After PALL come tRP NOP cycles and then one idle cycle, so a waiting request's ACTV follows PALL after exactly tRP+1 NOPs. `req_ready` is low from ACTV until the sequencer is idle again.
- R6: With the timer enabled, the request is raised reload+1 cycles after enabling, and the count restarts from the reload value. The flag is sticky. Further expiries while it is pending queue no second refresh.
- R7: A refresh request raised during a burst does not alter that burst. The refresh PALL follows one idle cycle after the burst's tRP wait.
- R8: A refresh cycle is PALL, tRP NOPs, REFRESH (`cmd_n`=0001), then recovery NOPs. Starting it clears the request.
- R9: While a refresh is pending or running, `req_ready` is low. A request held meanwhile gets its ACTV exactly recovery+1 NOPs after REFRESH.
- R10: NOP is encoded as 0111 on (CS, RAS, CAS, WE), and no other code appears between commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_en | input | 1 | Refresh timer enable; low holds the timer at the reload value |
| rfsh_reload | input | 16 | Refresh timer reload value |
| t_rcd | input | 4 | Row-to-column NOP count |
| t_rwl | input | 4 | Write-to-precharge NOP count |
| t_rp | input | 4 | Precharge recovery NOP count |
| t_rfc | input | 4 | Auto-refresh recovery NOP count |
| req_valid | input | 1 | Host access request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_row | input | 13 | Row address |
| req_cols | input | 36 | Column list, column k at bits [9k+8:9k] |
| req_size | input | 5 | Transfer size in bytes |
| req_ready | output | 1 | Request accepted on a clock edge where this and req_valid are high |
| cmd_n | output | 4 | Active-low CS, RAS, CAS, WE |
| addr | output | 13 | SDRAM address bus |

## Verification
The assertions assume that the delay inputs and the reload value stay stable while a burst or refresh is in flight. They also assume that `req_size` is a non-zero multiple of the port width no larger than the column list. The bench changes timing inputs only after the sequencer has been idle for several cycles, and it issues only sizes of one to four beats. The refresh-deferral case enables the timer in the same cycle as a request. This makes the expiry fall inside the row-to-column wait, where the block's own behaviour is exercised rather than that of an out-of-range input.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // Active-low {CS, RAS, CAS, WE}
    typedef enum logic [3:0] {
        CMD_NOP  = 4'b0111,
        CMD_ACT  = 4'b0011,
        CMD_RD   = 4'b0101,
        CMD_WR   = 4'b0100,
        CMD_PALL = 4'b0010,
        CMD_REF  = 4'b0001
    } sdram_cmd_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ACT,
        S_RCD,
        S_COL,
        S_RWL,
        S_PALL,
        S_RP,
        S_RF_PALL,
        S_RF_RP,
        S_RF_AREF,
        S_RF_REC
    } seq_state_t;

    localparam int A10_BIT = 10;

endpackage

// File: rtl/sdram_rfsh_timer.sv
module sdram_rfsh_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] reload,
    input  logic             clr,
    output logic             pend
);

    logic [CNT_W-1:0] cnt;
    logic             expire;

    assign expire = en && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (!en || expire) cnt <= reload;
            else               cnt <= cnt - 1'b1;

            if (expire)   pend <= 1'b1;
            else if (clr) pend <= 1'b0;
        end
    end

    AST_EXPIRE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend);                                   // R6
    AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt == $past(reload)));                 // R6
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);                           // R6

endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W      = 13,
    parameter int COL_W      = 9,
    parameter int ADDR_W     = 13,
    parameter int MAX_BEATS  = 4,
    parameter int PORT_BYTES = 4,
    parameter int SIZE_W     = 5,
    parameter int DLY_W      = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rfsh_pend,
    output logic                       rfsh_start,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ROW_W-1:0]           req_row,
    input  logic [MAX_BEATS*COL_W-1:0] req_cols,
    input  logic [SIZE_W-1:0]          req_size,
    input  logic [DLY_W-1:0]           t_rcd,
    input  logic [DLY_W-1:0]           t_rwl,
    input  logic [DLY_W-1:0]           t_rp,
    input  logic [DLY_W-1:0]           t_rfc,
    output logic                       req_ready,
    output logic [3:0]                 cmd_n,
    output logic [ADDR_W-1:0]          addr
);

    localparam int BEAT_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
    localparam int PB_SH  = $clog2(PORT_BYTES);

    seq_state_t                 state;
    logic [DLY_W-1:0]           cnt;
    logic [BEAT_W-1:0]          beat;
    logic [BEAT_W-1:0]          last_beat;
    logic                       wr_q;
    logic [ROW_W-1:0]           row_q;
    logic [MAX_BEATS*COL_W-1:0] cols_q;
    logic [SIZE_W-1:0]          beats_in;
    logic [COL_W-1:0]           col_now;
    sdram_cmd_t                 cmd;
    logic                       wait_done;

    assign beats_in  = req_size >> PB_SH;
    assign col_now   = cols_q[beat*COL_W +: COL_W];
    assign wait_done = (cnt <= DLY_W'(1));

    // State register and sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            beat      <= '0;
            last_beat <= '0;
            wr_q      <= 1'b0;
            row_q     <= '0;
            cols_q    <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (rfsh_pend) begin
                        state <= S_RF_PALL;
                    end else if (req_valid) begin
                        wr_q      <= req_write;
                        row_q     <= req_row;
                        cols_q    <= req_cols;
                        last_beat <= BEAT_W'(beats_in - 1'b1);
                        state     <= S_ACT;
                    end
                end
                S_ACT: begin
                    beat  <= '0;
                    cnt   <= t_rcd;
                    state <= (t_rcd == '0) ? S_COL : S_RCD;
                end
                S_RCD: begin
                    if (wait_done) state <= S_COL;
                    else           cnt   <= cnt - 1'b1;
                end
                S_COL: begin
                    if (beat == last_beat) begin
                        if (wr_q && (t_rwl != '0)) begin
                            cnt   <= t_rwl;
                            state <= S_RWL;
                        end else begin
                            state <= S_PALL;
                        end
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                S_RWL: begin
                    if (wait_done) state <= S_PALL;
                    else           cnt   <= cnt - 1'b1;
                end
                S_PALL: begin
                    cnt   <= t_rp;
                    state <= (t_rp == '0) ? S_IDLE : S_RP;
                end
                S_RP: begin
                    if (wait_done) state <= S_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                S_RF_PALL: begin
                    cnt   <= t_rp;
                    state <= (t_rp == '0) ? S_RF_AREF : S_RF_RP;
                end
                S_RF_RP: begin
                    if (wait_done) state <= S_RF_AREF;
                    else           cnt   <= cnt - 1'b1;
                end
                S_RF_AREF: begin
                    cnt   <= t_rfc;
                    state <= (t_rfc == '0) ? S_IDLE : S_RF_REC;
                end
                S_RF_REC: begin
                    if (wait_done) state <= S_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Command and address outputs
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        unique case (state)
            S_ACT: begin
                cmd  = CMD_ACT;
                addr = ADDR_W'(row_q);
            end
            S_COL: begin
                cmd  = wr_q ? CMD_WR : CMD_RD;
                addr = ADDR_W'(col_now);
            end
            S_PALL, S_RF_PALL: begin
                cmd           = CMD_PALL;
                addr[A10_BIT] = 1'b1;
            end
            S_RF_AREF: cmd = CMD_REF;
            default: ;
        endcase
    end

    assign cmd_n      = cmd;
    assign req_ready  = (state == S_IDLE) && !rfsh_pend;
    assign rfsh_start = (state == S_RF_PALL);

    AST_PALL_A10_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n == CMD_PALL) |-> addr[A10_BIT]);                        // R4
    AST_ACT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n == CMD_ACT) |-> $past(req_valid && req_ready));         // R9
    AST_RFSH_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RF_PALL) |-> ($past(state) == S_IDLE));            // R7
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cmd_n == CMD_NOP));                             // R5
    AST_REF_AFTER_PALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == S_RF_AREF) |-> ($past(state) inside {S_RF_PALL, S_RF_RP})); // R8

endmodule

// File: rtl/sdram_seq_top.sv
module sdram_seq_top #(
    parameter int ROW_W      = 13,
    parameter int COL_W      = 9,
    parameter int ADDR_W     = 13,
    parameter int MAX_BEATS  = 4,
    parameter int PORT_BYTES = 4,
    parameter int RFSH_W     = 16,
    parameter int DLY_W      = 4,
    localparam int SIZE_W    = $clog2(MAX_BEATS*PORT_BYTES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rfsh_en,
    input  logic [RFSH_W-1:0]          rfsh_reload,
    input  logic [DLY_W-1:0]           t_rcd,
    input  logic [DLY_W-1:0]           t_rwl,
    input  logic [DLY_W-1:0]           t_rp,
    input  logic [DLY_W-1:0]           t_rfc,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ROW_W-1:0]           req_row,
    input  logic [MAX_BEATS*COL_W-1:0] req_cols,
    input  logic [SIZE_W-1:0]          req_size,
    output logic                       req_ready,
    output logic [3:0]                 cmd_n,
    output logic [ADDR_W-1:0]          addr
);

    logic rfsh_pend;
    logic rfsh_start;

    sdram_rfsh_timer #(.CNT_W(RFSH_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (rfsh_en),
        .reload (rfsh_reload),
        .clr    (rfsh_start),
        .pend   (rfsh_pend)
    );

    sdram_cmd_fsm #(
        .ROW_W      (ROW_W),
        .COL_W      (COL_W),
        .ADDR_W     (ADDR_W),
        .MAX_BEATS  (MAX_BEATS),
        .PORT_BYTES (PORT_BYTES),
        .SIZE_W     (SIZE_W),
        .DLY_W      (DLY_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rfsh_pend  (rfsh_pend),
        .rfsh_start (rfsh_start),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_row    (req_row),
        .req_cols   (req_cols),
        .req_size   (req_size),
        .t_rcd      (t_rcd),
        .t_rwl      (t_rwl),
        .t_rp       (t_rp),
        .t_rfc      (t_rfc),
        .req_ready  (req_ready),
        .cmd_n      (cmd_n),
        .addr       (addr)
    );

endmodule

// File: tb/sim_sdram_seq_top.sv
`timescale 1ns/1ps
module sim_sdram_seq_top;

    localparam logic [3:0] C_NOP  = 4'b0111;
    localparam logic [3:0] C_ACT  = 4'b0011;
    localparam logic [3:0] C_RD   = 4'b0101;
    localparam logic [3:0] C_WR   = 4'b0100;
    localparam logic [3:0] C_PALL = 4'b0010;
    localparam logic [3:0] C_REF  = 4'b0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rfsh_en = 1'b0;
    logic [15:0] rfsh_reload = 16'd0;
    logic [3:0]  t_rcd = 4'd0, t_rwl = 4'd0, t_rp = 4'd0, t_rfc = 4'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_row = '0;
    logic [35:0] req_cols = '0;
    logic [4:0]  req_size = '0;
    logic        req_ready;
    logic [3:0]  cmd_n;
    logic [12:0] addr;

    int checks = 0;
    int errors = 0;
    int gap = 0;

    typedef struct {
        logic [3:0]  cmd;
        logic [12:0] addr;
        int          gap;
        string       req;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    sdram_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .rfsh_en(rfsh_en), .rfsh_reload(rfsh_reload),
        .t_rcd(t_rcd), .t_rwl(t_rwl), .t_rp(t_rp), .t_rfc(t_rfc),
        .req_valid(req_valid), .req_write(req_write), .req_row(req_row),
        .req_cols(req_cols), .req_size(req_size), .req_ready(req_ready),
        .cmd_n(cmd_n), .addr(addr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [3:0] c, input logic [12:0] a, input int g, input string r);
        exp_t e;
        e.cmd = c; e.addr = a; e.gap = g; e.req = r;
        exp_q.push_back(e);
    endtask

    // Expected command stream of one burst
    task automatic push_burst(input bit wr, input logic [12:0] row, input logic [35:0] cols,
                              input int nbeats, input int act_gap, input int rcd, input int rwl);
        push(C_ACT, row, act_gap, "R2");
        for (int k = 0; k < nbeats; k++)
            push(wr ? C_WR : C_RD, {4'd0, cols[k*9 +: 9]}, (k == 0) ? rcd : 0,
                 (k == 0) ? "R2" : "R3");
        push(C_PALL, 13'h400, wr ? rwl : 0, "R4");
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst_n) begin
            gap = 0;
        end else if (cmd_n == C_NOP) begin
            gap++;
        end else begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected command", int'(cmd_n), int'(C_NOP));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cmd_n == e.cmd, e.req, "command code", int'(cmd_n), int'(e.cmd));
                check(addr == e.addr, e.req, "address", int'(addr), int'(e.addr));
                if (e.gap >= 0)
                    check(gap == e.gap, e.req, "NOP cycles before command", gap, e.gap);
            end
            gap = 0;
        end
    end

    // Driver: called at a negedge, returns at the negedge after acceptance
    task automatic drive(input bit wr, input logic [12:0] row, input logic [35:0] cols,
                         input logic [4:0] size);
        req_write = wr; req_row = row; req_cols = cols; req_size = size;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R5", "ready low during burst", int'(req_ready), 0);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(cmd_n == C_NOP, "R10", "NOP during reset", int'(cmd_n), int'(C_NOP));
        rst_n = 1'b1;
        settle(2);
        check(cmd_n == C_NOP, "R1", "NOP after reset", int'(cmd_n), int'(C_NOP));
        check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);

        // Write 4 beats then back-to-back write 2 beats
        t_rcd = 4'd2; t_rwl = 4'd1; t_rp = 4'd2; t_rfc = 4'd3;
        push_burst(1'b1, 13'h1A5, {9'h155, 9'h1F0, 9'h007, 9'h003}, 4, -1, 2, 1);
        drive(1'b1, 13'h1A5, {9'h155, 9'h1F0, 9'h007, 9'h003}, 5'd16);
        push_burst(1'b1, 13'h0F0, {18'd0, 9'h0AA, 9'h011}, 2, 3, 2, 1);  // R5 gap tRP+1
        drive(1'b1, 13'h0F0, {18'd0, 9'h0AA, 9'h011}, 5'd8);
        settle(20);

        // Read 2 beats with zero delays, then a single-beat write
        t_rcd = 4'd0; t_rwl = 4'd0; t_rp = 4'd0;
        settle(2);
        push_burst(1'b0, 13'h003, {18'd0, 9'h1FF, 9'h100}, 2, -1, 0, 0);
        drive(1'b0, 13'h003, {18'd0, 9'h1FF, 9'h100}, 5'd8);
        push_burst(1'b1, 13'h1FFF, {27'd0, 9'h042}, 1, 1, 0, 0);
        drive(1'b1, 13'h1FFF, {27'd0, 9'h042}, 5'd4);
        settle(10);

        // Refresh while idle, request held during refresh
        t_rcd = 4'd1; t_rwl = 4'd2; t_rp = 4'd1; t_rfc = 4'd2;
        rfsh_reload = 16'd40;
        settle(2);
        push(C_PALL, 13'h400, -1, "R8");
        push(C_REF, 13'h000, 1, "R8");
        rfsh_en = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (req_ready);
        check(n == 41, "R6", "cycles from enable to request", n, 41);
        push_burst(1'b0, 13'h077, {27'd0, 9'h033}, 1, 3, 1, 0);  // R9 gap tRFC+1
        drive(1'b0, 13'h077, {27'd0, 9'h033}, 5'd4);
        rfsh_en = 1'b0;
        settle(20);
        check(exp_q.size() == 0, "R8", "pending expected commands", exp_q.size(), 0);

        // Refresh deferred behind a burst; repeated expiries queue one refresh
        t_rcd = 4'd3; t_rwl = 4'd2; t_rp = 4'd2; t_rfc = 4'd1;
        rfsh_reload = 16'd3;
        settle(2);
        push_burst(1'b1, 13'h0C3, {9'h0F0, 9'h00F, 9'h181, 9'h018}, 4, -1, 3, 2);
        push(C_PALL, 13'h400, 3, "R7");
        push(C_REF, 13'h000, 2, "R8");
        rfsh_en = 1'b1;
        drive(1'b1, 13'h0C3, {9'h0F0, 9'h00F, 9'h181, 9'h018}, 5'd16);
        settle(9);
        rfsh_en = 1'b0;
        settle(40);
        check(exp_q.size() == 0, "R6", "pending expected commands", exp_q.size(), 0);
        check(req_ready == 1'b1, "R9", "ready after refresh", int'(req_ready), 1);
        check(cmd_n == C_NOP, "R10", "idle command", int'(cmd_n), int'(C_NOP));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule